// File: doc/BRIEF.md
# Linear Burst Request Engine with In-Flight Cap

This block generates a stream of address-channel requests for one direction of an AXI memory port, either read or write, chosen by a parameter. It walks a configured address window linearly, one burst at a time. When the whole window has been requested it starts again at the window's first address. Each time the window wraps, it raises a one-cycle marker.

The engine limits how many accepted transactions may await their completion. It spreads consecutive requests over a rotating set of transaction IDs, and it can be slowed to a percentage of full request rate. For every burst it measures the number of cycles from the address handshake to the completion handshake. It keeps a running total of those cycles and a count of completed bursts, so software can form an average latency by dividing one by the other.

A run is active while `runEn` is high. While `runEn` is low the engine reloads its window position from the configuration inputs and launches nothing. A request already presented on the address channel is still held until it is accepted.

Top module: `burst_requester`

## Requirements
- R1: After reset, `axValid`, `blockDone`, `latSum` and `burstCnt` are 0, and `respReady` is 1.
- R2: Consecutive accepted requests carry consecutive addresses. Each address is the previous one plus (`axLen`+1) × `DATA_W`/8 bytes, starting at `startOffset`. `axLen` is the beat count minus one, and the beat count is `burstBeats`.
- R3: No request crosses a 4096-byte address boundary. A burst that would cross one is shortened so that it ends at the boundary, and the next burst starts on the boundary.
- R4: Once the last burst of the `blockBytes` window has been launched, the next request starts again at `startOffset`. `blockDone` is high for exactly one cycle, in the cycle where that last burst first appears on `axValid`.
- R5: The number of requests that have been accepted but not yet completed never exceeds `outLimit`, and it reaches `outLimit` when the responder is slow. An `outLimit` of 0 means no configured limit, so only the timestamp depth `TS_DEPTH` bounds it. A limit above `TS_DEPTH` is also bounded by `TS_DEPTH`.
- R6: In the read variant (`IS_READ`=1), a transaction completes only on a beat where `respValid`, `respLast` and `respReady` are all high. Beats that are not last neither free a slot nor count. In the write variant, every `respValid`&`respReady` cycle completes one transaction.
- R7: With `singleThread` low and `threadCnt`=N, the IDs of consecutive requests are 0, 1, …, N-1 and then 0 again. With `singleThread` high, every request uses ID 0.
- R8: With `ratePct`=r, an always-ready address channel and no slot limit, consecutive address handshakes are exactly ceil(100/r) cycles apart. For example, r=100 gives 1 cycle, r=50 gives 2 and r=30 gives 4.
- R9: Each completion adds to `latSum` the number of cycles from that burst's address handshake edge to its completion edge, and adds 1 to `burstCnt`. Completions are matched to handshakes in issue order.
- R10: Once raised, `axValid` stays high and `axAddr`, `axLen` and `axId` stay stable until `axReady` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | High to generate requests; low reloads the window position |
| startOffset | input | ADDR_W | First byte address of the window (aligned to the beat size) |
| blockBytes | input | ADDR_W | Window size in bytes (a multiple of the beat size, nonzero) |
| burstBeats | input | LEN_W+1 | Requested beats per burst (0 is treated as 1; capped at 2^LEN_W) |
| outLimit | input | OUTS_W | Cap on accepted-but-incomplete requests; 0 means uncapped |
| ratePct | input | 7 | Request rate in percent, 1 to 100 |
| threadCnt | input | ID_W+1 | Number of IDs in the rotation |
| singleThread | input | 1 | Forces ID 0 for every request |
| axValid | output | 1 | Address channel valid |
| axReady | input | 1 | Address channel ready |
| axAddr | output | ADDR_W | Burst start byte address |
| axLen | output | LEN_W | Beats in the burst minus one |
| axId | output | ID_W | Transaction ID |
| respValid | input | 1 | Response valid (R beat or B response) |
| respLast | input | 1 | Last beat of a read burst (ignored for writes) |
| respReady | output | 1 | Response ready, always high |
| blockDone | output | 1 | One-cycle marker for the final burst of the window |
| latSum | output | CNT_W | Accumulated per-burst latency in cycles |
| burstCnt | output | CNT_W | Number of completed bursts |

## Verification
The address walk is driven with a window that fits evenly into bursts and with a window that starts just below a 4 KiB boundary. The first shows linear stepping and wrapping; the second shows that boundary splitting and the shortened final burst are separate effects. The in-flight cap is tried at a small limit with a slow responder and at limit 0 with a slower one, which separates the configured cap from the timestamp-depth cap. Rates of 100, 50 and 30 percent tell an exact credit scheme apart from an off-by-one one. A manually driven read burst shows that a non-last beat cannot release a slot. Latency is checked both with a fixed responder delay, one burst at a time, and with many bursts overlapping, so that the timestamp ordering is exercised.

// File: rtl/burstreq_pkg.sv
package burstreq_pkg;

  // Strobes passed from the control to the datapath, one cycle wide each.
  typedef struct packed {
    logic launch;    // a new request is loaded onto the address channel
    logic accept;    // address handshake in this cycle
    logic complete;  // completion handshake in this cycle
    logic reload;    // run disabled: reload window position
  } reqStrobes_t;

  localparam int unsigned RATE_FULL = 100;

endpackage

// File: rtl/burstreq_ctrl.sv
module burstreq_ctrl
  import burstreq_pkg::*;
#(
  parameter int ID_W     = 2,
  parameter int OUTS_W   = 8,
  parameter int TS_DEPTH = 16,
  parameter bit IS_READ  = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic                haveWork,
  input  logic [OUTS_W-1:0]   outLimit,
  input  logic [6:0]          ratePct,
  input  logic [ID_W:0]       threadCnt,
  input  logic                singleThread,
  input  logic                axReady,
  input  logic                respValid,
  input  logic                respLast,
  output logic                respReady,
  output logic                axValid,
  output logic [ID_W-1:0]     axId,
  output reqStrobes_t         st
);

  localparam int IF_W = $clog2(TS_DEPTH + 1);
  localparam int CW   = ((OUTS_W > IF_W) ? OUTS_W : IF_W) + 1;

  logic [IF_W-1:0] inFlight;
  logic [CW-1:0]   capEff;
  logic [CW-1:0]   occ;
  logic [7:0]      credit;
  logic [7:0]      rateEff;
  logic [7:0]      creditSum;
  logic [ID_W-1:0] idCnt;
  logic            compHit;
  logic            slotOk;
  logic            rateOk;
  logic            launch;
  logic            accept;

  assign respReady = 1'b1;

  generate
    if (IS_READ) begin : g_rdDone
      assign compHit = respValid & respLast;
    end else begin : g_wrDone
      assign compHit = respValid;
    end
  endgenerate

  always_comb begin
    if (outLimit == '0 || CW'(outLimit) > CW'(TS_DEPTH)) capEff = CW'(TS_DEPTH);
    else                                                capEff = CW'(outLimit);
    occ = CW'(inFlight) + CW'(axValid);
    slotOk = occ < capEff;

    if (ratePct == 7'd0)                  rateEff = 8'd1;
    else if (ratePct > 7'(RATE_FULL))     rateEff = 8'(RATE_FULL);
    else                                  rateEff = {1'b0, ratePct};
    creditSum = credit + rateEff;
    rateOk = credit >= 8'(RATE_FULL);

    accept = axValid & axReady;
    launch = runEn & haveWork & rateOk & slotOk & (~axValid | axReady);

    st.launch   = launch;
    st.accept   = accept;
    st.complete = compHit & respReady;
    st.reload   = ~runEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      axValid  <= 1'b0;
      axId     <= '0;
      idCnt    <= '0;
      credit   <= 8'(RATE_FULL);
      inFlight <= '0;
    end else begin
      if (launch)      axValid <= 1'b1;
      else if (accept) axValid <= 1'b0;

      if (launch) axId <= singleThread ? '0 : idCnt;

      if (!runEn || singleThread) idCnt <= '0;
      else if (launch) begin
        if (({1'b0, idCnt} + 1'b1) >= threadCnt) idCnt <= '0;
        else                                    idCnt <= idCnt + 1'b1;
      end

      if (!runEn)                          credit <= 8'(RATE_FULL);
      else if (launch)                     credit <= rateEff;
      else if (creditSum >= 8'(RATE_FULL)) credit <= 8'(RATE_FULL);
      else                                 credit <= creditSum;

      inFlight <= inFlight + IF_W'(accept) - IF_W'(st.complete);
    end
  end

endmodule

// File: rtl/burstreq_dp.sv
module burstreq_dp
  import burstreq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 512,
  parameter int LEN_W    = 8,
  parameter int TS_DEPTH = 16,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  reqStrobes_t       st,
  input  logic [ADDR_W-1:0] startOffset,
  input  logic [ADDR_W-1:0] blockBytes,
  input  logic [LEN_W:0]    burstBeats,
  output logic              haveWork,
  output logic [ADDR_W-1:0] axAddr,
  output logic [LEN_W-1:0]  axLen,
  output logic              blockDone,
  output logic [CNT_W-1:0]  latSum,
  output logic [CNT_W-1:0]  burstCnt
);

  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BEAT_SH    = $clog2(BEAT_BYTES);
  localparam int PAGE_SH    = 12;
  localparam int PAGE_BEATS = (1 << PAGE_SH) / BEAT_BYTES;
  localparam int BW         = ADDR_W - BEAT_SH;
  localparam int MAX_BEATS  = 1 << LEN_W;
  localparam int PTR_W      = $clog2(TS_DEPTH);

  logic [ADDR_W-1:0] curAddr;
  logic [BW-1:0]     remBeats;
  logic [BW-1:0]     blockBeatsIn;
  logic [BW-1:0]     toPage;
  logic [BW-1:0]     wantBeats;
  logic [BW-1:0]     pickBeats;
  logic              lastOne;

  logic [CNT_W-1:0]  tNow;
  logic [CNT_W-1:0]  tsMem [TS_DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  // Burst sizing: requested length, clipped at the page edge and the window end.
  always_comb begin
    blockBeatsIn = blockBytes[ADDR_W-1:BEAT_SH];
    toPage = BW'(PAGE_BEATS) - BW'(curAddr[PAGE_SH-1:BEAT_SH]);
    if (burstBeats == '0)                   wantBeats = BW'(1);
    else if (BW'(burstBeats) > BW'(MAX_BEATS)) wantBeats = BW'(MAX_BEATS);
    else                                    wantBeats = BW'(burstBeats);
    pickBeats = wantBeats;
    if (toPage < pickBeats)   pickBeats = toPage;
    if (remBeats < pickBeats) pickBeats = remBeats;
    lastOne  = (pickBeats == remBeats);
    haveWork = (remBeats != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remBeats  <= '0;
      axAddr    <= '0;
      axLen     <= '0;
      blockDone <= 1'b0;
    end else begin
      blockDone <= st.launch & lastOne;
      if (st.launch) begin
        axAddr <= curAddr;
        axLen  <= LEN_W'(pickBeats - 1'b1);
      end
      if (st.reload || (st.launch && lastOne)) begin
        curAddr  <= startOffset;
        remBeats <= blockBeatsIn;
      end else if (st.launch) begin
        curAddr  <= curAddr + {pickBeats, {BEAT_SH{1'b0}}};
        remBeats <= remBeats - pickBeats;
      end
    end
  end

  // Issue-order timestamps for latency.
  always_ff @(posedge clk) begin
    if (st.accept) tsMem[wrPtr] <= tNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tNow     <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      latSum   <= '0;
      burstCnt <= '0;
    end else begin
      tNow <= tNow + 1'b1;
      if (st.accept) wrPtr <= wrPtr + 1'b1;
      if (st.complete) begin
        rdPtr    <= rdPtr + 1'b1;
        latSum   <= latSum + (tNow - tsMem[rdPtr]);
        burstCnt <= burstCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_requester.sv
module burst_requester
  import burstreq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 512,
  parameter int ID_W     = 2,
  parameter int LEN_W    = 8,
  parameter int OUTS_W   = 8,
  parameter int TS_DEPTH = 16,
  parameter int CNT_W    = 32,
  parameter bit IS_READ  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [ADDR_W-1:0] startOffset,
  input  logic [ADDR_W-1:0] blockBytes,
  input  logic [LEN_W:0]    burstBeats,
  input  logic [OUTS_W-1:0] outLimit,
  input  logic [6:0]        ratePct,
  input  logic [ID_W:0]     threadCnt,
  input  logic              singleThread,
  output logic              axValid,
  input  logic              axReady,
  output logic [ADDR_W-1:0] axAddr,
  output logic [LEN_W-1:0]  axLen,
  output logic [ID_W-1:0]   axId,
  input  logic              respValid,
  input  logic              respLast,
  output logic              respReady,
  output logic              blockDone,
  output logic [CNT_W-1:0]  latSum,
  output logic [CNT_W-1:0]  burstCnt
);

  reqStrobes_t st;
  logic        haveWork;

  burstreq_ctrl #(
    .ID_W(ID_W), .OUTS_W(OUTS_W), .TS_DEPTH(TS_DEPTH), .IS_READ(IS_READ)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .haveWork(haveWork),
    .outLimit(outLimit), .ratePct(ratePct), .threadCnt(threadCnt),
    .singleThread(singleThread), .axReady(axReady), .respValid(respValid),
    .respLast(respLast), .respReady(respReady), .axValid(axValid),
    .axId(axId), .st(st)
  );

  burstreq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .TS_DEPTH(TS_DEPTH), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .startOffset(startOffset),
    .blockBytes(blockBytes), .burstBeats(burstBeats), .haveWork(haveWork),
    .axAddr(axAddr), .axLen(axLen), .blockDone(blockDone),
    .latSum(latSum), .burstCnt(burstCnt)
  );

endmodule

// File: rtl/burstreq_chk.sv
module burstreq_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 512,
  parameter int ID_W     = 2,
  parameter int LEN_W    = 8,
  parameter int OUTS_W   = 8,
  parameter int TS_DEPTH = 16,
  parameter int CNT_W    = 32,
  parameter bit IS_READ  = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [OUTS_W-1:0] outLimit,
  input logic              singleThread,
  input logic              axValid,
  input logic              axReady,
  input logic [ADDR_W-1:0] axAddr,
  input logic [LEN_W-1:0]  axLen,
  input logic [ID_W-1:0]   axId,
  input logic              respValid,
  input logic              respLast,
  input logic              respReady,
  input logic              blockDone,
  input logic [CNT_W-1:0]  burstCnt
);

  localparam int BEAT_BYTES = DATA_W / 8;

  int  pendCnt;
  int  capVal;
  logic doneHs;

  assign doneHs = respValid & respReady & (IS_READ ? respLast : 1'b1);

  always_comb begin
    if (outLimit == '0 || int'(outLimit) > TS_DEPTH) capVal = TS_DEPTH;
    else                                           capVal = int'(outLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendCnt <= 0;
    else       pendCnt <= pendCnt + int'(axValid & axReady) - int'(doneHs);
  end

  p_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= capVal);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (axValid && !axReady) |=> (axValid && $stable(axAddr) && $stable(axLen) && $stable(axId)));

  p_page_r3: assert property (@(posedge clk) disable iff (!rstN)
    axValid |-> (int'(axAddr[11:0]) + (int'(axLen) + 1) * BEAT_BYTES <= 4096));

  p_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |-> axValid);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (burstCnt != $past(burstCnt)) |-> (burstCnt - $past(burstCnt) == CNT_W'(1)));

  p_single_id_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(axValid) && singleThread && $past(singleThread)) |-> (axId == '0));

endmodule

bind burst_requester burstreq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W),
  .OUTS_W(OUTS_W), .TS_DEPTH(TS_DEPTH), .CNT_W(CNT_W), .IS_READ(IS_READ)
) u_chk (
  .clk(clk), .rstN(rstN), .outLimit(outLimit), .singleThread(singleThread),
  .axValid(axValid), .axReady(axReady), .axAddr(axAddr), .axLen(axLen),
  .axId(axId), .respValid(respValid), .respLast(respLast),
  .respReady(respReady), .blockDone(blockDone), .burstCnt(burstCnt)
);

// File: tb/burst_requester_tb.sv
`timescale 1ns/1ps
module burst_requester_tb;

  localparam int ADDR_W = 32;
  localparam int ID_W   = 2;
  localparam int LEN_W  = 8;
  localparam int OUTS_W = 8;
  localparam int CNT_W  = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              runEn;
  logic [ADDR_W-1:0] startOffset;
  logic [ADDR_W-1:0] blockBytes;
  logic [LEN_W:0]    burstBeats;
  logic [OUTS_W-1:0] outLimit;
  logic [6:0]        ratePct;
  logic [ID_W:0]     threadCnt;
  logic              singleThread;
  logic              axValid;
  logic              axReady;
  logic [ADDR_W-1:0] axAddr;
  logic [LEN_W-1:0]  axLen;
  logic [ID_W-1:0]   axId;
  logic              respValid;
  logic              respLast;
  logic              respReady;
  logic              blockDone;
  logic [CNT_W-1:0]  latSum;
  logic [CNT_W-1:0]  burstCnt;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int cyc = 0;
  int hsCount, compCount, inflight, maxInflight, bdCount;
  int hsAddr [64];
  int hsLen  [64];
  int hsId   [64];
  int hsCyc  [64];
  int compCyc[64];
  bit autoOn;
  int respDelay, respIdx, beat;

  always #2.5 clk = ~clk;

  burst_requester u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .startOffset(startOffset),
    .blockBytes(blockBytes), .burstBeats(burstBeats), .outLimit(outLimit),
    .ratePct(ratePct), .threadCnt(threadCnt), .singleThread(singleThread),
    .axValid(axValid), .axReady(axReady), .axAddr(axAddr), .axLen(axLen),
    .axId(axId), .respValid(respValid), .respLast(respLast),
    .respReady(respReady), .blockDone(blockDone), .latSum(latSum),
    .burstCnt(burstCnt)
  );

  // Port monitor: records handshakes at the edge where they happen.
  always @(posedge clk) begin
    if (rstN) begin
      if (axValid && axReady) begin
        if (hsCount < 64) begin
          hsAddr[hsCount] = int'(axAddr);
          hsLen[hsCount]  = int'(axLen);
          hsId[hsCount]   = int'(axId);
          hsCyc[hsCount]  = cyc;
        end
        hsCount++;
        inflight++;
      end
      if (respValid && respReady && respLast) begin
        if (compCount < 64) compCyc[compCount] = cyc;
        compCount++;
        inflight--;
      end
      if (inflight > maxInflight) maxInflight = inflight;
      if (blockDone) bdCount++;
    end
    cyc++;
  end

  // In-order responder: beats start respDelay cycles after the handshake.
  always @(negedge clk) begin
    if (rstN && autoOn) begin
      if (respValid) begin
        if (respLast) begin respIdx++; beat = 0; end
        else beat++;
      end
      respValid = 1'b0;
      respLast  = 1'b0;
      if (respIdx < hsCount && respIdx < 64 && cyc >= hsCyc[respIdx] + respDelay) begin
        respValid = 1'b1;
        respLast  = (beat == hsLen[respIdx]);
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; runEn = 1'b0; axReady = 1'b1; autoOn = 1'b1;
    respValid = 1'b0; respLast = 1'b0;
    startOffset = '0; blockBytes = 32'd1024; burstBeats = 9'd1;
    outLimit = '0; ratePct = 7'd100; threadCnt = 3'd1; singleThread = 1'b0;
    respDelay = 2; respIdx = 0; beat = 0;
    hsCount = 0; compCount = 0; inflight = 0; maxInflight = 0; bdCount = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic runFor(input int n);
    runEn = 1'b1;
    repeat (n) @(negedge clk);
    runEn = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 axValid", axValid, 0);
    chk("R1 blockDone", blockDone, 0);
    chk("R1 latSum", latSum, 0);
    chk("R1 burstCnt", burstCnt, 0);
    chk("R1 respReady", respReady, 1);
  endtask

  task automatic testLinear();
    int nWrap;
    doReset();
    startOffset = 32'h1000; blockBytes = 32'd1024; burstBeats = 9'd4;
    repeat (2) @(negedge clk);
    runFor(6);
    chk("R2 handshake count", (hsCount >= 5) ? 1 : 0, 1);
    nWrap = 0;
    for (int i = 0; i < hsCount && i < 64; i++) begin
      chk("R2/R4 address", hsAddr[i], 32'h1000 + (i % 4) * 256);
      chk("R2 length", hsLen[i], 3);
      if (hsAddr[i] == 32'h1300) nWrap++;
    end
    chk("R4 blockDone pulses", bdCount, nWrap);
    chk("R4 at least one wrap", (nWrap >= 1) ? 1 : 0, 1);
  endtask

  task automatic testPage();
    doReset();
    startOffset = 32'h0F80; blockBytes = 32'd1024; burstBeats = 9'd8;
    repeat (2) @(negedge clk);
    runFor(4);
    chk("R3 count", (hsCount >= 4) ? 1 : 0, 1);
    chk("R3 addr0", hsAddr[0], 32'h0F80); chk("R3 len0", hsLen[0], 1);
    chk("R3 addr1", hsAddr[1], 32'h1000); chk("R3 len1", hsLen[1], 7);
    chk("R3 addr2", hsAddr[2], 32'h1200); chk("R3 len2", hsLen[2], 5);
    chk("R4 addr3 wrap", hsAddr[3], 32'h0F80); chk("R3 len3", hsLen[3], 1);
  endtask

  task automatic testLimit();
    longint expLat;
    doReset();
    outLimit = 8'd2; respDelay = 6;
    repeat (2) @(negedge clk);
    runFor(30);
    chk("R5 limit 2 peak", maxInflight, 2);
    doReset();
    outLimit = 8'd0; respDelay = 30;
    repeat (2) @(negedge clk);
    runFor(25);
    chk("R5 limit 0 peak at depth", maxInflight, 16);
    chk("R9 all completed", compCount, hsCount);
    chk("R9 burstCnt", burstCnt, compCount);
    expLat = 0;
    for (int i = 0; i < compCount && i < 64; i++) expLat += compCyc[i] - hsCyc[i];
    chk("R9 overlapped latSum", latSum, expLat);
  endtask

  task automatic testLast();
    doReset();
    autoOn = 1'b0; outLimit = 8'd1; burstBeats = 9'd4;
    repeat (2) @(negedge clk);
    runEn = 1'b1;
    while (hsCount < 1) @(negedge clk);
    repeat (3) begin respValid = 1'b1; respLast = 1'b0; @(negedge clk); end
    respValid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 no completion on non-last", burstCnt, 0);
    chk("R6 slot still held", hsCount, 1);
    respValid = 1'b1; respLast = 1'b1; @(negedge clk);
    respValid = 1'b0; respLast = 1'b0;
    repeat (4) @(negedge clk);
    runEn = 1'b0;
    chk("R6 completion on last", burstCnt, 1);
    chk("R6 slot released", hsCount, 2);
  endtask

  task automatic testIds();
    doReset();
    threadCnt = 3'd3;
    repeat (2) @(negedge clk);
    runFor(7);
    chk("R7 count", (hsCount >= 6) ? 1 : 0, 1);
    for (int i = 0; i < hsCount && i < 64; i++) chk("R7 rotating id", hsId[i], i % 3);
    doReset();
    threadCnt = 3'd3; singleThread = 1'b1;
    repeat (2) @(negedge clk);
    runFor(5);
    for (int i = 0; i < hsCount && i < 64; i++) chk("R7 single id", hsId[i], 0);
  endtask

  task automatic testRate(input int r, input int gap, input int n);
    doReset();
    ratePct = 7'(r);
    repeat (2) @(negedge clk);
    runFor(n);
    chk("R8 count", (hsCount >= 4) ? 1 : 0, 1);
    for (int i = 0; i + 1 < hsCount && i + 1 < 64; i++)
      chk($sformatf("R8 spacing at %0d%%", r), hsCyc[i + 1] - hsCyc[i], gap);
  endtask

  task automatic testLatency();
    longint expLat;
    doReset();
    outLimit = 8'd1; respDelay = 3;
    repeat (2) @(negedge clk);
    runEn = 1'b1;
    while (hsCount < 4) @(negedge clk);
    runEn = 1'b0;
    repeat (30) @(negedge clk);
    chk("R9 burstCnt", burstCnt, 4);
    chk("R9 latSum fixed delay", latSum, 12);
    expLat = 0;
    for (int i = 0; i < compCount && i < 64; i++) expLat += compCyc[i] - hsCyc[i];
    chk("R9 latSum vs ports", latSum, expLat);
  endtask

  task automatic testHold();
    logic [ADDR_W-1:0] firstAddr;
    doReset();
    startOffset = 32'h0200; axReady = 1'b0;
    repeat (2) @(negedge clk);
    runEn = 1'b1;
    repeat (3) @(negedge clk);
    firstAddr = axAddr;
    chk("R10 valid raised", axValid, 1);
    repeat (3) @(negedge clk);
    chk("R10 valid held", axValid, 1);
    chk("R10 addr held", axAddr, firstAddr);
    chk("R10 no handshake", hsCount, 0);
    runEn = 1'b0; axReady = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 one accepted", hsCount, 1);
    chk("R10 first addr", hsAddr[0], 32'h0200);
  endtask

  initial begin
    testReset();
    testLinear();
    testPage();
    testLimit();
    testLast();
    testIds();
    testRate(100, 1, 6);
    testRate(50, 2, 12);
    testRate(30, 4, 20);
    testLatency();
    testHold();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #750000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule